// File: doc/BRIEF.md
# SD Card Clock Divider with Settle and Gate Control

This block derives the clock sent to an SD card from the host's base clock. A 16-bit control word selects the division ratio and turns the internal divider on. It also reports when the divider has settled, and it separately lets the card clock out to the pin. Two divisor formats are decoded, and a version input picks one. The legacy format accepts only powers of two in an 8-bit field. The extended format takes a 10-bit value N and divides by 2N, with its two upper bits stored in a separate part of the word. A read-only capabilities word reports the base clock frequency in MHz.

The block is clocked by `clk`, which runs at twice the base clock rate. A division ratio R (the base clock divided by R) therefore gives a card clock whose high time and low time are each R cycles of `clk`. Software first writes zero to stop the clock. It then writes the divisor with the internal enable set, polls the stable flag, and only after that sets the card clock enable. The card clock output starts and stops only at a low phase, so no pulse is ever cut short.

Top module: `sdclk_ctrl`

## Requirements
- R1: After reset the control readback is 0x0000 and the card clock output is low.
- R2: Control bits 15:8, 7:6, 2 and 0 read back as last written. Bits 5:3 always read zero, and a write to bit 1 has no effect on its readback.
- R3: The capabilities word carries the base clock frequency in MHz (parameter, default 50) in bits 15:8, and zero in bits 7:0.
- R4: Bit 1 (stable) reads 1 exactly SETTLE_CYC cycles after the write edge that set bit 0 (internal enable), default 16. The write is sampled at one edge, and the flag reads 1 after the edge SETTLE_CYC later.
- R5: Stable reads 0 one edge after bit 0 is written to zero, or after the decoded ratio R changes, whether through a divisor write or through the version input. Settling then starts again.
- R6: With the extended format selected (version input 1), N = {bits 7:6, bits 15:8}. R = 2N when N is nonzero, and R = 1 when N is zero.
- R7: With the legacy format selected (version input 0), F = bits 15:8 and bits 7:6 are ignored. R = 1 when F is zero; otherwise R = 2P, where P is the smallest power of two that is at least F.
- R8: While bit 2 (card clock enable) or stable is 0, the card clock does not rise. Once both are 1, the output runs with period 2R cycles and holds its level for R cycles in each phase.
- R9: If card clock enable is cleared during a high phase, the output stays high until that phase has lasted R cycles, then falls and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the base clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enc_new_i | input | 1 | Divisor format: 1 extended 10-bit, 0 legacy power-of-two |
| ctl_wr_i | input | 1 | Write strobe for the control word |
| ctl_wdata_i | input | 16 | Control word write data |
| ctl_rdata_o | output | 16 | Control word readback, including the stable flag |
| cap_o | output | 16 | Capabilities word, base clock MHz in bits 15:8 |
| sd_clk_o | output | 1 | Gated, divided card clock |

## Verification
The divider is run with extended values N = 0, 3 and 256; the last one exercises the upper two bits, which sit in a separate field. It is also run with legacy values F = 0, 2 (upper field bits set, to show they are ignored), 3, 128 and 129. An exact power of two and values that must round up are therefore measured against each other. A cycle-level model predicts every output on every clock, and this shows apart an off-by-one in the half period, a wrong rounding direction, and a wrong field concatenation. Further checks toggle the version input and clear the enable while the clock runs, which separates a correct restart of settling from a stale stable flag. Clearing card clock enable in mid high phase shows whether the output is truncated.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int LO_W  = 8;
  localparam int HI_W  = 2;
  localparam int RAT_W = LO_W + HI_W + 2;

  // Division ratio R for the chosen format: the card clock half period in clk cycles.
  function automatic logic [RAT_W-1:0] ratio_of(input logic [LO_W-1:0] lo,
                                                input logic [HI_W-1:0] hi,
                                                input logic            ext);
    logic [RAT_W-1:0] n;
    logic [RAT_W-1:0] p;
    if (ext) begin
      n = RAT_W'({hi, lo});
      ratio_of = (n == '0) ? RAT_W'(1) : (n << 1);
    end else if (lo == '0) begin
      ratio_of = RAT_W'(1);
    end else begin
      p = RAT_W'(1);
      for (int i = 0; i < LO_W; i++) begin
        if (p < RAT_W'(lo)) p = p << 1;
      end
      ratio_of = p << 1;
    end
  endfunction
endpackage

// File: rtl/sdclk_ctl_regs.sv
module sdclk_ctl_regs
  import sdclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [15:0]         wdata_i,
  input  logic                ext_i,
  output logic [LO_W-1:0]     lo_q_o,
  output logic [HI_W-1:0]     hi_q_o,
  output logic                card_q_o,
  output logic                ien_q_o,
  output logic                ien_d_o,
  output logic [RAT_W-1:0]    ratio_q_o,
  output logic [RAT_W-1:0]    ratio_d_o
);
  logic [LO_W-1:0]  lo_d;
  logic [HI_W-1:0]  hi_d;
  logic             card_d;
  logic             ien_d;
  logic [RAT_W-1:0] ratio_d;

  always_comb begin
    lo_d   = lo_q_o;
    hi_d   = hi_q_o;
    card_d = card_q_o;
    ien_d  = ien_q_o;
    if (wr_i) begin
      lo_d   = wdata_i[15:8];
      hi_d   = wdata_i[7:6];
      card_d = wdata_i[2];
      ien_d  = wdata_i[0];
    end
    ratio_d = ratio_of(lo_d, hi_d, ext_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q_o    <= '0;
      hi_q_o    <= '0;
      card_q_o  <= 1'b0;
      ien_q_o   <= 1'b0;
      ratio_q_o <= RAT_W'(1);
    end else begin
      lo_q_o    <= lo_d;
      hi_q_o    <= hi_d;
      card_q_o  <= card_d;
      ien_q_o   <= ien_d;
      ratio_q_o <= ratio_d;
    end
  end

  assign ien_d_o   = ien_d;
  assign ratio_d_o = ratio_d;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable({lo_q_o, hi_q_o, card_q_o, ien_q_o}));
endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle
  import sdclk_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_q_i,
  input  logic             ien_d_i,
  input  logic [RAT_W-1:0] ratio_q_i,
  input  logic [RAT_W-1:0] ratio_d_i,
  output logic             stable_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          restart;

  always_comb begin
    restart = !ien_d_i || (ratio_d_i != ratio_q_i);
    cnt_d   = cnt_q;
    if (restart) cnt_d = '0;
    else if (ien_q_i && (cnt_q != CMAX)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stable_o = (cnt_q == CMAX);

  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !stable_o);
  assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable_o) |-> $past(ien_q_i));
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [RAT_W-1:0] ratio_i,
  output logic             sd_o
);
  logic [RAT_W-1:0] half_q;
  logic [RAT_W-1:0] half_d;
  logic             sd_q;
  logic             sd_d;

  always_comb begin
    half_d = '0;
    sd_d   = 1'b0;
    if (run_i || sd_q) begin
      if (half_q >= ratio_i - 1'b1) begin
        half_d = '0;
        sd_d   = !sd_q;
      end else begin
        half_d = half_q + 1'b1;
        sd_d   = sd_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      sd_q   <= 1'b0;
    end else begin
      half_q <= half_d;
      sd_q   <= sd_d;
    end
  end

  assign sd_o = sd_q;

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !sd_q) |=> !sd_q);
  assert_rise_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_q) |-> $past(run_i));
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int BASE_MHZ   = 50,
  parameter int SETTLE_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enc_new_i,
  input  logic        ctl_wr_i,
  input  logic [15:0] ctl_wdata_i,
  output logic [15:0] ctl_rdata_o,
  output logic [15:0] cap_o,
  output logic        sd_clk_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [LO_W-1:0]  lo_q;
  logic [HI_W-1:0]  hi_q;
  logic             card_q;
  logic             ien_q;
  logic             ien_d;
  logic [RAT_W-1:0] ratio_q;
  logic [RAT_W-1:0] ratio_d;
  logic             stable;
  logic             run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdclk_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_i      (ctl_wr_i),
    .wdata_i   (ctl_wdata_i),
    .ext_i     (enc_new_i),
    .lo_q_o    (lo_q),
    .hi_q_o    (hi_q),
    .card_q_o  (card_q),
    .ien_q_o   (ien_q),
    .ien_d_o   (ien_d),
    .ratio_q_o (ratio_q),
    .ratio_d_o (ratio_d)
  );

  sdclk_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ien_q_i   (ien_q),
    .ien_d_i   (ien_d),
    .ratio_q_i (ratio_q),
    .ratio_d_i (ratio_d),
    .stable_o  (stable)
  );

  assign run = card_q && stable;

  sdclk_gen u_gen (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run_i   (run),
    .ratio_i (ratio_q),
    .sd_o    (sd_clk_o)
  );

  assign ctl_rdata_o = {lo_q, hi_q, 3'b000, card_q, stable, ien_q};
  assign cap_o       = {8'(BASE_MHZ), 8'h00};
endmodule

// File: tb/sdclk_ctrl_tb.sv
module sdclk_ctrl_tb;
  localparam int BASE   = 50;
  localparam int SETTLE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_new = 1'b1;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] cap;
  logic        sd;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  sdclk_ctrl #(.BASE_MHZ(BASE), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .enc_new_i(enc_new), .ctl_wr_i(wr),
    .ctl_wdata_i(wdata), .ctl_rdata_o(rdata), .cap_o(cap), .sd_clk_o(sd)
  );

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int f_ratio(input int lo, input int hi, input logic ext);
    int n;
    n = hi * 256 + lo;
    if (ext) return (n == 0) ? 1 : 2 * n;
    if (lo == 0) return 1;
    return 2 * (1 << $clog2(lo));
  endfunction

  // Reference model, behavioural
  int m_lo, m_hi, m_card, m_ien, m_ratio, m_cnt, m_half, m_sd;
  always @(posedge clk or negedge rst_n) begin
    int nlo, nhi, ncard, nien, nr, run;
    if (!rst_n) begin
      m_lo <= 0; m_hi <= 0; m_card <= 0; m_ien <= 0;
      m_ratio <= 1; m_cnt <= 0; m_half <= 0; m_sd <= 0;
    end else begin
      nlo = wr ? int'(wdata[15:8]) : m_lo;
      nhi = wr ? int'(wdata[7:6])  : m_hi;
      ncard = wr ? int'(wdata[2])  : m_card;
      nien  = wr ? int'(wdata[0])  : m_ien;
      nr = f_ratio(nlo, nhi, enc_new);
      run = (m_card != 0) && (m_cnt == SETTLE);
      if (nien == 0 || nr != m_ratio) m_cnt <= 0;
      else if (m_ien != 0 && m_cnt < SETTLE) m_cnt <= m_cnt + 1;
      if (run != 0 || m_sd != 0) begin
        if (m_half >= m_ratio - 1) begin m_half <= 0; m_sd <= 1 - m_sd; end
        else m_half <= m_half + 1;
      end else begin
        m_half <= 0; m_sd <= 0;
      end
      m_lo <= nlo; m_hi <= nhi; m_card <= ncard; m_ien <= nien; m_ratio <= nr;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    logic [15:0] exp_r;
    if (rst_n) begin
      exp_r = {8'(m_lo), 2'(m_hi), 3'b000, 1'(m_card), (m_cnt == SETTLE), 1'(m_ien)};
      chk({cur_req, " readback"}, rdata === exp_r, int'(rdata), int'(exp_r));
      chk({cur_req, " card clock"}, sd === 1'(m_sd), int'(sd), m_sd);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog R8 actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr_ctl(input logic [15:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wait_stable(input string req);
    int c = 0;
    while (!rdata[1] && c < 2000) begin @(negedge clk); c++; end
    chk(req, rdata[1] === 1'b1, int'(rdata[1]), 1);
  endtask

  task automatic measure(input string req, input int exp_p);
    logic prev;
    int n = 0;
    int guard = 0;
    prev = sd;
    @(negedge clk);
    while (!(!prev && sd) && guard < 5000) begin prev = sd; @(negedge clk); guard++; end
    prev = sd;
    @(negedge clk); n = 1;
    while (!(!prev && sd) && n < 5000) begin prev = sd; @(negedge clk); n++; end
    chk(req, n == exp_p, n, exp_p);
  endtask

  initial begin
    int c;
    int h;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, R3 capabilities
    chk("R1", rdata === 16'h0000, int'(rdata), 0);
    chk("R1", sd === 1'b0, int'(sd), 0);
    chk("R3", cap === {8'(BASE), 8'h00}, int'(cap), BASE * 256);

    // R2: stored fields read back, bit 1 write ignored, bits 5:3 zero
    cur_req = "R2";
    wr_ctl(16'hFFFE);
    chk("R2", rdata === 16'hFFC4, int'(rdata), 16'hFFC4);
    cur_req = "R8";
    repeat (20) @(negedge clk);
    chk("R8", sd === 1'b0, int'(sd), 0);
    wr_ctl(16'h0000);

    // R4: settle latency with extended N=3
    cur_req = "R4";
    wr_ctl(16'h0301);
    c = 0;
    while (!rdata[1] && c < 100) begin @(negedge clk); c++; end
    chk("R4", c == SETTLE, c, SETTLE);

    // R6: extended encoding periods
    cur_req = "R6";
    wr_ctl(16'h0305);
    measure("R6 N=3", 12);
    wr_ctl(16'h0005);
    wait_stable("R6");
    measure("R6 N=0", 2);
    wr_ctl(16'h0045);
    wait_stable("R6");
    measure("R6 N=256", 1024);

    // R9: stop in the middle of a high phase
    cur_req = "R9";
    wr_ctl(16'h0305);
    wait_stable("R9");
    prev = sd;
    @(negedge clk);
    while (!(!prev && sd)) begin prev = sd; @(negedge clk); end
    wr = 1'b1; wdata = 16'h0301;
    h = 1;
    @(negedge clk); wr = 1'b0;
    while (sd && h < 100) begin h++; @(negedge clk); end
    chk("R9", h == 6, h, 6);
    c = 0;
    repeat (30) begin @(negedge clk); if (sd) c++; end
    chk("R9", c == 0, c, 0);

    // R5: version change alters R and restarts settling
    cur_req = "R5";
    wr_ctl(16'h0305);
    wait_stable("R5");
    enc_new = 1'b0;
    @(negedge clk);
    chk("R5", rdata[1] === 1'b0, int'(rdata[1]), 0);

    // R7: legacy encoding
    cur_req = "R7";
    wait_stable("R7");
    measure("R7 F=3", 16);
    wr_ctl(16'h02C5);
    wait_stable("R7");
    measure("R7 F=2 hi ignored", 8);
    wr_ctl(16'h0005);
    wait_stable("R7");
    measure("R7 F=0", 2);
    wr_ctl(16'h8005);
    wait_stable("R7");
    measure("R7 F=128", 512);
    wr_ctl(16'h8105);
    wait_stable("R7");
    measure("R7 F=129", 1024);

    // R5: writing zero drops stable
    cur_req = "R5";
    wr_ctl(16'h0000);
    chk("R5", rdata[1] === 1'b0, int'(rdata[1]), 0);
    repeat (600) @(negedge clk);
    chk("R5", sd === 1'b0, int'(sd), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule